// File: doc/BRIEF.md
# Board Control and Timekeeping Register Block

This block is a memory-mapped board control peripheral on a 4 KB window of a 32-bit register bus. It drives two indicator LEDs, reports the state of two push buttons, holds a 32-bit general control word whose bits fan out to neighbouring board logic, and keeps two free-running time counters. One counter advances once per second and the other once every 10 ms. Both rates are derived from the main clock, whose frequency is a parameter. Software can preload either counter at any time, and counting carries on from the loaded value.

The bus is a plain request interface. A request is a cycle with the valid input high, a write flag, a byte address and write data. Writes take effect at that clock edge. A read returns its data on the registered data output in the following cycle, together with a one-cycle response strobe. Registers are selected by address bits [11:2], so the two low address bits play no part. Data is little-endian, with bit 0 as the least significant bit. The offsets 0x18, 0x1C and 0x20 belong to a prescaled event counter that lives in a companion block. In this block they are unmapped.

A small access state machine tracks what the previous bus cycle was. It has three states. In IDLE, no access was accepted. In RD_DONE, a read was accepted and its data is now presented. In WR_DONE, a write was accepted. The transitions are taken every cycle and depend only on the current request: no request goes to IDLE, a read request goes to RD_DONE, and a write request goes to WR_DONE. There are no other transitions.

Top module: `board_timekeep`

## Requirements
- R1: After reset the LED outputs, the control word, both time counters, the read data and the response strobe are all zero.
- R2: A write to offset 0x00 keeps only write-data bits [1:0], which appear on `led_o` from the next cycle. A read of 0x00 returns them in bits [1:0], with zeros above.
- R3: A read of offset 0x08 returns `btn_i` after a two-stage synchronizer in bits [1:0], with zeros above. Writes to 0x08 have no effect.
- R4: Offset 0x4C is a 32-bit read/write control word. It is driven on `misc_o`, reads back as written, and changes only when written.
- R5: The 10 ms counter at offset 0x14 increases by exactly one every CLK_HZ/100 clock cycles and otherwise holds its value.
- R6: The one-second counter at offset 0x10 increases by exactly one every CLK_HZ clock cycles.
- R7: A write to either counter loads the written value and restarts its divider. A read issued m idle cycles after the write returns V + floor(m / period).
- R8: Both counters are 32 bits wide and wrap from 0xFFFFFFFF to 0.
- R9: A read of any offset other than 0x00, 0x08, 0x10, 0x14 and 0x4C returns zero, including the companion offsets 0x18, 0x1C and 0x20. A write to such an offset changes nothing.
- R10: Read data and the response strobe are registered and appear in the cycle after the read request. In other cycles the data is zero and the strobe is low. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, CLK_HZ hertz |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid_i | input | 1 | Request present this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read response strobe |
| btn_i | input | 2 | Asynchronous push-button levels |
| led_o | output | 2 | LED drive |
| misc_o | output | 32 | Control word to neighbouring logic |

## Verification
The counters are swept with every idle gap from zero to several periods after a preload. This separates a divider whose phase restarts on a write from one that keeps its old phase, and it exposes an off-by-one in the period. The one-second counter is probed on both sides of its period boundary. A preload of all ones shows the wrap. The register side is driven with all-ones and sparse data patterns, with reads of every companion offset and of an unmapped offset, and with writes to read-only and unmapped offsets. These tell masking, decode aliasing and stray write enables apart.

// File: rtl/bt_pkg.sv
package bt_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = ADDR_W - 2;

    localparam logic [IDX_W-1:0] IDX_LED  = IDX_W'(12'h000 >> 2);
    localparam logic [IDX_W-1:0] IDX_BTN  = IDX_W'(12'h008 >> 2);
    localparam logic [IDX_W-1:0] IDX_SEC  = IDX_W'(12'h010 >> 2);
    localparam logic [IDX_W-1:0] IDX_CSEC = IDX_W'(12'h014 >> 2);
    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(12'h04C >> 2);

    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_RD_DONE = 2'd1,
        ACC_WR_DONE = 2'd2
    } acc_state_t;

    function automatic logic idx_mapped(input logic [IDX_W-1:0] idx);
        return (idx == IDX_LED) || (idx == IDX_BTN) || (idx == IDX_SEC) ||
               (idx == IDX_CSEC) || (idx == IDX_CTRL);
    endfunction
endpackage

// File: rtl/bt_btn_sync.sv
module bt_btn_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic meta_q;
            logic stab_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_i[g];
                    stab_q <= meta_q;
                end
            end
            assign sync_o[g] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/bt_tick_counter.sv
module bt_tick_counter #(
    parameter int DIV   = 100,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] count_o
);
    localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0]  phase_q;
    logic [WIDTH-1:0] count_q;
    logic             wrap_phase;

    assign wrap_phase = (phase_q == PH_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            count_q <= '0;
        end else if (load_i) begin
            phase_q <= '0;
            count_q <= load_val_i;
        end else if (wrap_phase) begin
            phase_q <= '0;
            count_q <= count_q + WIDTH'(1);
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/board_timekeep.sv
module board_timekeep #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid_i,
    input  logic        bus_write_i,
    input  logic [11:0] bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        bus_rvalid_o,
    input  logic [1:0]  btn_i,
    output logic [1:0]  led_o,
    output logic [31:0] misc_o
);
    import bt_pkg::*;

    localparam int SEC_DIV  = CLK_HZ;
    localparam int CSEC_DIV = CLK_HZ / 100;

    acc_state_t        state_q;
    acc_state_t        state_d;
    logic [IDX_W-1:0]  word_idx;
    logic              rd_req;
    logic              wr_req;
    logic              unused_byte_lane;
    logic [1:0]        led_q;
    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  rdata_q;
    logic [REG_W-1:0]  rd_mux;
    logic [1:0]        btn_sync;
    logic [REG_W-1:0]  sec_count;
    logic [REG_W-1:0]  csec_count;

    assign word_idx         = bus_addr_i[ADDR_W-1:2];
    assign unused_byte_lane = ^bus_addr_i[1:0];
    assign rd_req           = bus_valid_i && !bus_write_i;
    assign wr_req           = bus_valid_i && bus_write_i;

    // access state machine: next state
    always_comb begin
        state_d = ACC_IDLE;
        if (wr_req)      state_d = ACC_WR_DONE;
        else if (rd_req) state_d = ACC_RD_DONE;
    end

    // access state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // access state machine: outputs
    always_comb begin
        bus_rvalid_o = 1'b0;
        unique case (state_q)
            ACC_IDLE:    bus_rvalid_o = 1'b0;
            ACC_RD_DONE: bus_rvalid_o = 1'b1;
            ACC_WR_DONE: bus_rvalid_o = 1'b0;
            default:     bus_rvalid_o = 1'b0;
        endcase
    end

    bt_btn_sync #(.N(2)) i_btn_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (btn_i),
        .sync_o  (btn_sync)
    );

    bt_tick_counter #(.DIV(SEC_DIV), .WIDTH(REG_W)) i_sec_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_req && (word_idx == IDX_SEC)),
        .load_val_i (bus_wdata_i),
        .count_o    (sec_count)
    );

    bt_tick_counter #(.DIV(CSEC_DIV), .WIDTH(REG_W)) i_csec_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_req && (word_idx == IDX_CSEC)),
        .load_val_i (bus_wdata_i),
        .count_o    (csec_count)
    );

    // plain registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_req) begin
            if (word_idx == IDX_LED)  led_q  <= bus_wdata_i[1:0];
            if (word_idx == IDX_CTRL) ctrl_q <= bus_wdata_i;
        end
    end

    // read select
    always_comb begin
        rd_mux = '0;
        case (word_idx)
            IDX_LED:  rd_mux = {30'd0, led_q};
            IDX_BTN:  rd_mux = {30'd0, btn_sync};
            IDX_SEC:  rd_mux = sec_count;
            IDX_CSEC: rd_mux = csec_count;
            IDX_CTRL: rd_mux = ctrl_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata_o = rdata_q;
    assign led_o       = led_q;
    assign misc_o      = ctrl_q;
endmodule

// File: rtl/bt_chk.sv
module bt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid_i,
    input logic        bus_write_i,
    input logic [11:0] bus_addr_i,
    input logic [31:0] bus_wdata_i,
    input logic [31:0] bus_rdata_o,
    input logic        bus_rvalid_o,
    input logic [1:0]  led_o,
    input logic [31:0] misc_o,
    input logic [31:0] csec_count
);
    import bt_pkg::*;

    logic [IDX_W-1:0] idx;
    assign idx = bus_addr_i[11:2];

    // R2
    led_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_write_i && idx == IDX_LED) |=> (led_o == $past(bus_wdata_i[1:0])));

    // R4
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid_i && bus_write_i && idx == IDX_CTRL) |=> $stable(misc_o));

    // R7
    csec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_write_i && idx == IDX_CSEC) |=> (csec_count == $past(bus_wdata_i)));

    // R5
    csec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid_i && bus_write_i && idx == IDX_CSEC) |=>
        ((csec_count == $past(csec_count)) || (csec_count == $past(csec_count) + 32'd1)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && !bus_write_i && !idx_mapped(idx)) |=> (bus_rdata_o == 32'd0));

    // R10
    rvalid_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);

    // R10
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid_i && !bus_write_i) |=> (!bus_rvalid_o && bus_rdata_o == 32'd0));
endmodule

bind board_timekeep bt_chk i_bt_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid_i  (bus_valid_i),
    .bus_write_i  (bus_write_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .led_o        (led_o),
    .misc_o       (misc_o),
    .csec_count   (csec_count)
);

// File: tb/test_board_timekeep.sv
module test_board_timekeep;
    localparam int CLK_HZ = 200;
    localparam int SEC_P  = CLK_HZ;
    localparam int CSEC_P = CLK_HZ / 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid_i = 1'b0;
    logic        bus_write_i = 1'b0;
    logic [11:0] bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        bus_rvalid_o;
    logic [1:0]  btn_i = 2'b00;
    logic [1:0]  led_o;
    logic [31:0] misc_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    board_timekeep #(.CLK_HZ(CLK_HZ)) i_board_timekeep (
        .clk(clk), .rst_n(rst_n), .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .bus_rvalid_o(bus_rvalid_o), .btn_i(btn_i), .led_o(led_o), .misc_o(misc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_valid_i = 1'b0; bus_write_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = a;
        @(negedge clk);
        bus_valid_i = 1'b0;
        d = bus_rdata_o;
        chk("R10 rvalid", {31'd0, bus_rvalid_o}, 32'd1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 led", {30'd0, led_o}, 32'd0);
        chk("R1 misc", misc_o, 32'd0);
        chk("R1 rvalid", {31'd0, bus_rvalid_o}, 32'd0);
        chk("R1 rdata", bus_rdata_o, 32'd0);
        bus_rd(12'h010, rd); chk("R1 sec count", rd, 32'd0);
        bus_rd(12'h000, rd); chk("R1 led reg", rd, 32'd0);
        bus_rd(12'h04C, rd); chk("R1 misc reg", rd, 32'd0);

        // R2 LED masking
        bus_wr(12'h000, 32'hFFFF_FFFE);
        chk("R2 led_o", {30'd0, led_o}, 32'd2);
        bus_rd(12'h000, rd); chk("R2 led read", rd, 32'd2);
        bus_wr(12'h000, 32'h0000_0005);
        bus_rd(12'h000, rd); chk("R2 led read 2", rd, 32'd1);

        // R4 control word
        bus_wr(12'h04C, 32'hA5C3_0F81);
        chk("R4 misc_o", misc_o, 32'hA5C3_0F81);
        bus_rd(12'h04C, rd); chk("R4 misc read", rd, 32'hA5C3_0F81);
        // R10 low address bits ignored
        bus_rd(12'h04E, rd); chk("R10 byte lane alias", rd, 32'hA5C3_0F81);
        idle(1);
        chk("R10 rvalid idle", {31'd0, bus_rvalid_o}, 32'd0);
        chk("R10 rdata idle", bus_rdata_o, 32'd0);

        // R3 buttons
        btn_i = 2'b01; idle(3);
        bus_rd(12'h008, rd); chk("R3 button 01", rd, 32'd1);
        bus_wr(12'h008, 32'hFFFF_FFFF);
        bus_rd(12'h008, rd); chk("R3 button write ignored", rd, 32'd1);
        btn_i = 2'b10; idle(3);
        bus_rd(12'h008, rd); chk("R3 button 10", rd, 32'd2);

        // R9 unmapped offsets
        for (int k = 0; k < 4; k++) begin
            logic [11:0] a;
            a = (k == 0) ? 12'h018 : (k == 1) ? 12'h01C : (k == 2) ? 12'h020 : 12'hFFC;
            bus_wr(a, 32'hDEAD_BEEF);
            bus_rd(a, rd); chk("R9 unmapped read", rd, 32'd0);
        end
        bus_rd(12'h04C, rd); chk("R9 misc untouched", rd, 32'hA5C3_0F81);
        bus_rd(12'h000, rd); chk("R9 led untouched", rd, 32'd1);

        // R5 R7 10 ms counter sweep
        for (int m = 0; m < 4 * CSEC_P + 2; m++) begin
            bus_wr(12'h014, 32'd1000);
            idle(m);
            bus_rd(12'h014, rd);
            chk("R5 R7 csec gap", rd, 32'd1000 + 32'(m / CSEC_P));
        end

        // R6 R7 one-second counter boundaries
        for (int k = 0; k < 7; k++) begin
            int m;
            m = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? SEC_P - 1 : (k == 3) ? SEC_P :
                (k == 4) ? SEC_P + 1 : (k == 5) ? 2 * SEC_P - 1 : 2 * SEC_P;
            bus_wr(12'h010, 32'd5);
            idle(m);
            bus_rd(12'h010, rd);
            chk("R6 R7 sec gap", rd, 32'd5 + 32'(m / SEC_P));
        end

        // R8 wrap
        for (int m = 0; m < 2 * CSEC_P + 1; m++) begin
            bus_wr(12'h014, 32'hFFFF_FFFF);
            idle(m);
            bus_rd(12'h014, rd);
            chk("R8 csec wrap", rd, 32'hFFFF_FFFF + 32'(m / CSEC_P));
        end
        bus_wr(12'h010, 32'hFFFF_FFFF);
        idle(SEC_P);
        bus_rd(12'h010, rd);
        chk("R8 sec wrap", rd, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule